// File: doc/BRIEF.md
# Infrared Pulse and Gap Symbol Receiver

This peripheral watches a demodulated infrared line and turns each burst into a timing word. A burst starts on a rising edge. The block counts how long the line stays high (the pulse) and then how long it stays low (the gap). Both counts are in ticks of ten prescaled microseconds.

When the next rising edge arrives, the pulse and gap are packed into one 32-bit symbol and written into a small queue. If the line stays quiet for too long, the symbol is closed early and the stream is marked finished. Software reads the queue occupancy from one register and pops symbols by reading another. It is told of new data, of end-of-stream and of lost data through three maskable interrupt causes, each acknowledged by writing a one to a clear register.

Capture is driven by one state machine, `irrx_measure`, with four states:
- OFF: not armed.
- WAIT: armed, waiting for a rising edge.
- PULSE: counting high time.
- GAP: counting low time.

Its transitions are:
- arm: OFF to WAIT.
- first_rise: WAIT to PULSE.
- fall: PULSE to GAP.
- next_rise: GAP to PULSE, which pushes a symbol.
- expire: PULSE or GAP to WAIT, which pushes the last symbol.
- disarm: any state to OFF.

Top module: `irrx_capture`

## Requirements
- R1: After reset, the count register (0x20) reads 0, the interrupt status register (0x2C) reads 0, the busy register (0x1C) reads 0 and `irq` is low.
- R2: Writing 1 to bit 0 of the enable register (0x00) while the block is disabled makes busy read 1 for BUSY_CYCLES clock cycles, after which it reads 0.
- R3: A symbol word has the pulse tick count in bits 15:0 and the gap tick count in bits 31:16. One tick is 10 × (prescale + 1) clocks, where prescale is config bits 6:0. Counting is re-aligned at every line edge. A symbol is pushed on the rising edge that follows its gap.
- R4: When pulse + gap reaches the maximum width (config bits 31:16), the symbol is pushed at once. The timeout cause is set and capture returns to waiting for a rising edge. A line held high for the whole width gives the symbol {gap 0, pulse max}.
- R5: The count register returns the queue occupancy. Each read of the data register (0x24) returns the oldest symbol and removes it. A read of an empty queue returns 0 and leaves the count at 0.
- R6: The receive cause (status bit 24, masked copy bit 8) is set by a push that leaves at least (config bits 13:8) + 1 symbols queued.
- R7: A push into a full queue drops the new symbol and sets the overflow cause (bit 26, masked copy bit 10). The stored symbols stay unchanged and in order.
- R8: Writing 1 to bit 16, 17 or 18 of the clear register (0x30) clears the receive, timeout or overflow cause respectively. Zero bits have no effect. A cause that is set in the same cycle stays set.
- R9: Mask register (0x28) bits 0, 1 and 2 suppress the receive, timeout and overflow causes in `irq` and in status bits 8 to 10. Status bits 24 to 26 always show the unmasked causes.
- R10: Edges are ignored until the start register (0x34) is written while the block is enabled. Writing 0 to enable disarms capture.
- R11: When a push and a data-register pop fall in the same cycle, the count is unchanged and the popped word is the previous head.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| ir_in | input | 1 | Demodulated infrared line, asynchronous |
| irq | output | 1 | Interrupt request, OR of the unmasked causes |

## Verification
The closing rising edge of a symbol and a software pop of the data register can land on the same clock edge. The queue must then write and read together. The bench raises the line at a known clock and issues the data read exactly two cycles later, which is when the synchronised edge reaches the state machine. It then requires the count to be unchanged, the read word to be the old head and the next pop to return the freshly closed symbol.

// File: rtl/irrx_pkg.sv
package irrx_pkg;

    localparam int ADDR_W = 8;
    localparam int CNT_W  = 16;

    localparam logic [ADDR_W-1:0] A_ENABLE = 8'h00;
    localparam logic [ADDR_W-1:0] A_CONFIG = 8'h04;
    localparam logic [ADDR_W-1:0] A_BUSY   = 8'h1C;
    localparam logic [ADDR_W-1:0] A_COUNT  = 8'h20;
    localparam logic [ADDR_W-1:0] A_DATA   = 8'h24;
    localparam logic [ADDR_W-1:0] A_MASK   = 8'h28;
    localparam logic [ADDR_W-1:0] A_STATUS = 8'h2C;
    localparam logic [ADDR_W-1:0] A_CLEAR  = 8'h30;
    localparam logic [ADDR_W-1:0] A_START  = 8'h34;

    // cause indices: receive, timeout, overflow
    localparam int C_RCV = 0;
    localparam int C_TMO = 1;
    localparam int C_OVF = 2;
    localparam int NCAUSE = 3;

    localparam int ST_RAW_LSB = 24;
    localparam int ST_MSK_LSB = 8;
    localparam int CLR_LSB    = 16;

    localparam logic [31:0] CFG_RESET = 32'h3E80_0080;

    typedef enum logic [1:0] {
        MS_OFF,
        MS_WAIT,
        MS_PULSE,
        MS_GAP
    } meas_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] gap;
        logic [CNT_W-1:0] pulse;
    } sym_t;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == {CNT_W{1'b1}}) ? v : v + 1'b1;
    endfunction

endpackage

// File: rtl/irrx_tick.sv
module irrx_tick #(
    parameter int PW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [PW-1:0] presc,
    output logic          tick
);
    logic [PW-1:0] us_q;
    logic [3:0]    dec_q;
    logic          us_wrap;
    logic          dec_wrap;

    assign us_wrap  = (us_q == presc);
    assign dec_wrap = (dec_q == 4'd9);
    assign tick     = us_wrap && dec_wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            us_q  <= '0;
            dec_q <= '0;
        end else if (clear) begin
            us_q  <= '0;
            dec_q <= '0;
        end else if (us_wrap) begin
            us_q  <= '0;
            dec_q <= dec_wrap ? 4'd0 : dec_q + 4'd1;
        end else begin
            us_q <= us_q + 1'b1;
        end
    end
endmodule

// File: rtl/irrx_measure.sv
module irrx_measure
    import irrx_pkg::*;
#(
    parameter int PW = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             armed,
    input  logic             ir_in,
    input  logic [PW-1:0]    presc,
    input  logic [CNT_W-1:0] max_w,
    output logic             push,
    output sym_t             sym,
    output logic             timeout_evt
);
    meas_state_t state_q, state_d;
    logic s1_q, s2_q, s3_q;
    logic rise, fall;
    logic [CNT_W-1:0] pulse_q, gap_q;
    logic [CNT_W:0]   sum;
    logic counting, hit, tick, tick_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
            s3_q <= 1'b0;
        end else begin
            s1_q <= ir_in;
            s2_q <= s1_q;
            s3_q <= s2_q;
        end
    end

    assign rise     = s2_q && !s3_q;
    assign fall     = !s2_q && s3_q;
    assign counting = (state_q == MS_PULSE) || (state_q == MS_GAP);
    assign sum      = {1'b0, pulse_q} + {1'b0, gap_q};
    assign hit      = counting && (sum >= {1'b0, max_w});
    assign tick_clr = rise || fall || !counting;

    irrx_tick #(.PW(PW)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tick_clr),
        .presc (presc),
        .tick  (tick)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MS_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MS_OFF:   state_d = MS_WAIT;
            MS_WAIT:  if (rise) state_d = MS_PULSE;
            MS_PULSE: if (hit) state_d = MS_WAIT;
                      else if (fall) state_d = MS_GAP;
            MS_GAP:   if (hit) state_d = MS_WAIT;
                      else if (rise) state_d = MS_PULSE;
            default:  state_d = MS_OFF;
        endcase
        if (!armed) state_d = MS_OFF;
    end

    // width counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= '0;
            gap_q   <= '0;
        end else if (rise && !hit && (state_q == MS_WAIT || state_q == MS_GAP)) begin
            pulse_q <= '0;
            gap_q   <= '0;
        end else if (tick && state_q == MS_PULSE) begin
            pulse_q <= sat_inc(pulse_q);
        end else if (tick && state_q == MS_GAP) begin
            gap_q <= sat_inc(gap_q);
        end
    end

    // outputs
    always_comb begin
        push        = 1'b0;
        timeout_evt = 1'b0;
        sym.pulse   = pulse_q;
        sym.gap     = gap_q;
        if (armed) begin
            unique case (state_q)
                MS_PULSE: begin
                    push        = hit;
                    timeout_evt = hit;
                end
                MS_GAP: begin
                    push        = hit || rise;
                    timeout_evt = hit;
                end
                default: ;
            endcase
        end
    end

    assert_gap_zero_in_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == MS_PULSE) |-> (gap_q == '0));

    assert_expire_leaves_R4: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_evt |=> (state_q == MS_WAIT || state_q == MS_OFF));

endmodule

// File: rtl/irrx_fifo.sv
module irrx_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic [$clog2(DEPTH):0] count,
    output logic         full,
    output logic         empty
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [AW:0]   cnt_q;
    logic do_push, do_pop;

    assign full    = (cnt_q == (AW+1)'(DEPTH));
    assign empty   = (cnt_q == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head    = empty ? '0 : mem[rp_q];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
            if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
            else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
        end
    end

    assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= (AW+1)'(DEPTH));

    assert_pushpop_same_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (do_push && do_pop) |=> $stable(cnt_q));

endmodule

// File: rtl/irrx_capture.sv
module irrx_capture
    import irrx_pkg::*;
#(
    parameter int DEPTH       = 8,
    parameter int BUSY_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              ir_in,
    output logic              irq
);
    localparam int QW = $clog2(DEPTH) + 1;
    localparam int BW = $clog2(BUSY_CYCLES + 1);

    logic        enable_q, armed_q;
    logic [31:0] cfg_q;
    logic [NCAUSE-1:0] mask_q, pend_q, set_v, clr_v, shown;
    logic [BW-1:0] busy_q;

    logic wr, rd, pop;
    logic sym_push, tmo_evt;
    sym_t sym;
    logic [31:0] head;
    logic [QW-1:0] count;
    logic full, empty;
    logic [QW:0] after_cnt;
    logic [6:0]  thr;

    assign wr  = bus_sel && bus_wr;
    assign rd  = bus_sel && !bus_wr;
    assign pop = rd && (bus_addr == A_DATA);

    irrx_measure #(.PW(7)) u_meas (
        .clk         (clk),
        .rst_n       (rst_n),
        .armed       (armed_q),
        .ir_in       (ir_in),
        .presc       (cfg_q[6:0]),
        .max_w       (cfg_q[31:16]),
        .push        (sym_push),
        .sym         (sym),
        .timeout_evt (tmo_evt)
    );

    irrx_fifo #(.W(32), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (sym_push),
        .wdata (sym),
        .pop   (pop),
        .head  (head),
        .count (count),
        .full  (full),
        .empty (empty)
    );

    // control registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= 1'b0;
            armed_q  <= 1'b0;
            cfg_q    <= CFG_RESET;
            mask_q   <= '0;
            busy_q   <= '0;
        end else begin
            if (busy_q != '0) busy_q <= busy_q - 1'b1;
            if (wr) begin
                unique case (bus_addr)
                    A_ENABLE: begin
                        enable_q <= bus_wdata[0];
                        if (!bus_wdata[0]) armed_q <= 1'b0;
                        if (bus_wdata[0] && !enable_q) busy_q <= BW'(BUSY_CYCLES);
                    end
                    A_CONFIG: cfg_q  <= bus_wdata;
                    A_MASK:   mask_q <= bus_wdata[NCAUSE-1:0];
                    A_START:  if (enable_q) armed_q <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    // interrupt causes
    assign after_cnt = {1'b0, count} + 1'b1 - {{QW{1'b0}}, (pop && !empty)};
    assign thr       = {1'b0, cfg_q[13:8]} + 7'd1;

    always_comb begin
        set_v        = '0;
        set_v[C_RCV] = sym_push && (!full || (pop && !empty)) &&
                       ({{(7 > QW+1 ? 7-QW-1 : 0){1'b0}}, after_cnt} >= thr);
        set_v[C_TMO] = tmo_evt;
        set_v[C_OVF] = sym_push && full && !pop;
        clr_v = (wr && bus_addr == A_CLEAR) ? bus_wdata[CLR_LSB +: NCAUSE] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= set_v | (pend_q & ~clr_v);
    end

    assign shown = pend_q & ~mask_q;
    assign irq   = |shown;

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (rd) begin
            unique case (bus_addr)
                A_ENABLE: bus_rdata = {31'b0, enable_q};
                A_CONFIG: bus_rdata = cfg_q;
                A_BUSY:   bus_rdata = {31'b0, (busy_q != '0)};
                A_COUNT:  bus_rdata = 32'(count);
                A_DATA:   bus_rdata = head;
                A_MASK:   bus_rdata = {{(32-NCAUSE){1'b0}}, mask_q};
                A_STATUS: begin
                    bus_rdata[ST_RAW_LSB +: NCAUSE] = pend_q;
                    bus_rdata[ST_MSK_LSB +: NCAUSE] = shown;
                end
                default: bus_rdata = '0;
            endcase
        end
    end

    assert_mask_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !irq);

    assert_clear_rcv_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_CLEAR && bus_wdata[CLR_LSB] && !set_v[C_RCV])
            |=> !pend_q[C_RCV]);

    assert_ovf_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_push && full && !pop) |=> (count == QW'(DEPTH)));

    assert_disarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && bus_addr == A_ENABLE && !bus_wdata[0]) |=> !sym_push);

endmodule

// File: tb/tb_irrx_capture.sv
module tb_irrx_capture;
    localparam int BUSY = 8;
    localparam int MAXW = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        ir_in = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam int NV = 4;
    localparam int VP[NV] = '{3, 5, 1, 7};
    localparam int VG[NV] = '{2, 4, 1, 3};
    localparam int EG[NV] = '{2, 4, 1, MAXW - 7};

    always #2.5 clk = ~clk;

    irrx_capture #(.DEPTH(8), .BUSY_CYCLES(BUSY)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ir_in     (ir_in),
        .irq       (irq)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog expired act=%0d exp<%0d", cycles, 150000);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic drive_sym(input int p, input int g);
        ir_in = 1'b1;
        repeat (10 * p + 5) @(negedge clk);
        ir_in = 1'b0;
        repeat (10 * g + 5) @(negedge clk);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(8'h20, v); check("R1 count", v, 32'h0);
        bus_read(8'h2C, v); check("R1 status", v, 32'h0);
        bus_read(8'h1C, v); check("R1 busy", v, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // R2 busy window
        bus_write(8'h00, 32'h1);
        bus_read(8'h1C, v); check("R2 busy set", v, 32'h1);
        repeat (5) @(negedge clk);
        bus_read(8'h1C, v); check("R2 busy held", v, 32'h1);
        repeat (3) @(negedge clk);
        bus_read(8'h1C, v); check("R2 busy done", v, 32'h0);

        // R10 edges ignored before start
        bus_write(8'h04, {16'(MAXW), 2'b00, 6'd2, 1'b1, 7'd0});
        bus_write(8'h28, 32'h0);
        drive_sym(2, 2);
        repeat (400) @(negedge clk);
        bus_read(8'h20, v); check("R10 no capture before start", v, 32'h0);

        // vector table: R3 R4 R5 R6
        bus_write(8'h34, 32'h1);
        for (int i = 0; i < NV; i++) drive_sym(VP[i], VG[i]);
        repeat (400) @(negedge clk);
        bus_read(8'h20, v); check("R5 count", v, 32'(NV));
        bus_read(8'h2C, v); check("R4 R6 status", v, 32'h0300_0300);
        check("R6 irq", {31'b0, irq}, 32'h1);
        for (int i = 0; i < NV; i++) begin
            bus_read(8'h24, v);
            check((i == NV - 1) ? "R4 timeout symbol" : "R3 symbol", v,
                  {16'(EG[i]), 16'(VP[i])});
        end

        // R8 clear
        bus_write(8'h30, 32'h0001_0000);
        bus_read(8'h2C, v); check("R8 clear rcv", v, 32'h0200_0200);
        bus_write(8'h30, 32'h0000_0000);
        bus_read(8'h2C, v); check("R8 zero write", v, 32'h0200_0200);
        bus_write(8'h30, 32'h0002_0000);
        bus_read(8'h2C, v); check("R8 clear tmo", v, 32'h0);

        // R5 empty read
        bus_read(8'h24, v); check("R5 empty data", v, 32'h0);
        bus_read(8'h20, v); check("R5 empty count", v, 32'h0);

        // R9 masked timeout; R4 line held high
        bus_write(8'h28, 32'h2);
        ir_in = 1'b1;
        repeat (400) @(negedge clk);
        ir_in = 1'b0;
        repeat (20) @(negedge clk);
        bus_read(8'h2C, v); check("R9 masked status", v, 32'h0200_0000);
        check("R9 irq masked", {31'b0, irq}, 32'h0);
        bus_read(8'h24, v); check("R4 held high", v, {16'd0, 16'(MAXW)});
        bus_write(8'h30, 32'h0007_0000);
        bus_write(8'h28, 32'h0);

        // R7 overflow
        for (int i = 0; i < 10; i++) drive_sym(i + 1, 1);
        repeat (400) @(negedge clk);
        bus_read(8'h20, v); check("R7 count full", v, 32'd8);
        bus_read(8'h2C, v); check("R7 ovf bit", {31'b0, v[26]}, 32'h1);
        check("R7 ovf low bit", {31'b0, v[10]}, 32'h1);
        for (int i = 0; i < 8; i++) begin
            bus_read(8'h24, v);
            check("R7 kept symbol", v, {16'd1, 16'(i + 1)});
        end
        bus_write(8'h30, 32'h0007_0000);
        bus_read(8'h2C, v); check("R8 clear all", v, 32'h0);

        // R11 push and pop together
        ir_in = 1'b1; repeat (25) @(negedge clk);
        ir_in = 1'b0; repeat (25) @(negedge clk);
        ir_in = 1'b1; repeat (35) @(negedge clk);
        ir_in = 1'b0; repeat (15) @(negedge clk);
        bus_read(8'h20, v); check("R11 pre count", v, 32'd1);
        ir_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_read(8'h24, v); check("R11 popped head", v, {16'd2, 16'd2});
        bus_read(8'h20, v); check("R11 count kept", v, 32'd1);
        bus_read(8'h24, v); check("R11 new symbol", v, {16'd1, 16'd3});

        // R10 disarm
        bus_write(8'h00, 32'h0);
        ir_in = 1'b0;
        drive_sym(2, 2);
        repeat (400) @(negedge clk);
        bus_read(8'h20, v); check("R10 disarmed", v, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule